// File: doc/BRIEF.md
# Masked Packed Double-to-Int64 Conversion Controller

This block converts a packed vector of IEEE-754 double-precision elements into signed 64-bit integers, one 64-bit lane at a time. A lane count of 2, 4 or 8 is selected by a vector-length code. Each active lane is either converted, merged from a prior destination vector, or zeroed, under a per-lane write mask. Destination bits above the selected vector length are always cleared.

A single control bit has two meanings. For a register source it enables an embedded rounding field at full vector length. For a memory source it replicates element 0 to every lane. The block reports invalid and inexact conditions, ORed over the lanes that were really converted. It raises an undefined-opcode fault when a 4-bit reserved specifier is not all ones. In that case the prior destination passes through untouched.

Operations are issued with a one-cycle `valid_in` pulse. All results appear together one clock later with `valid_out`.

Top module: `pvec_cvt_ctrl`

## Requirements
- R1: `vl_sel` selects the active lane count: 2'b00 gives 2 lanes, 2'b01 gives 4 lanes, 2'b10 and 2'b11 give 8 lanes. Lane j occupies bits [64j+63:64j] of every vector.
- R2: Destination bits from the selected vector length up to bit 511 are 0, whatever the mask.
- R3: An active lane takes its converted value when its `wmask` bit is 1 or when `mask_en` is 0.
- R4: With `mask_en`=1 and `zero_masking`=0, an active lane whose mask bit is 0 takes its value from `prior_vec`.
- R5: With `mask_en`=1 and `zero_masking`=1, an active lane whose mask bit is 0 is written with 0.
- R6: `wmask` bits at or above the active lane count affect neither the destination nor the flags.
- R7: Rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. `emb_rc` is used only when `mem_src`=0, `bcst_rnd`=1 and 8 lanes are active. Otherwise `glob_rc` is used.
- R8: With `mem_src`=1 and `bcst_rnd`=1, every lane converts `src_vec[63:0]`. With `bcst_rnd`=0, each lane converts its own element.
- R9: A lane result is the source value rounded to a signed 64-bit integer. NaN, infinity and values outside the signed 64-bit range give 64'h8000_0000_0000_0000 and set invalid. Any other rounded result that differs from the source sets inexact.
- R10: `exc_flags` bit 1 is invalid and bit 0 is inexact. Each is ORed only over lanes that are both active and converted.
- R11: When `resv_spec` is not 4'b1111, `ud_fault` is 1, `dest_vec` equals `prior_vec` on all 512 bits, and `exc_flags` is 0.
- R12: After reset all outputs are 0. `valid_out` is 1 exactly in the cycle after a `valid_in` cycle, and the results hold until the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Operation issue strobe |
| src_vec | input | 512 | Packed double-precision source |
| prior_vec | input | 512 | Prior destination contents for merging |
| wmask | input | 8 | Per-lane write mask |
| vl_sel | input | 2 | Vector length code |
| zero_masking | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| mask_en | input | 1 | 1 applies `wmask`, 0 writes all active lanes |
| mem_src | input | 1 | Source came from memory |
| bcst_rnd | input | 1 | Broadcast (memory) or embedded rounding (register) |
| emb_rc | input | 2 | Embedded rounding code |
| glob_rc | input | 2 | Global rounding code |
| resv_spec | input | 4 | Reserved specifier, must be 4'b1111 |
| valid_out | output | 1 | Result strobe, one cycle after `valid_in` |
| dest_vec | output | 512 | Packed signed 64-bit result |
| exc_flags | output | 2 | {invalid, inexact} |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
Every result of this block is due on the first rising edge after the `valid_in` cycle: destination, flags, fault and `valid_out` all come from a single register stage. The bench raises `valid_in` on a falling edge and lowers it on the next falling edge. It reads all outputs at that same falling edge, half a period after the capturing edge. One more falling edge later it confirms that `valid_out` has dropped while the results hold. The property checks use a one-cycle `|=>` offset from the issuing cycle, so the timing is the same for them.

// File: rtl/pvec_cvt_pkg.sv
// Shared types and constants for the packed conversion controller.
// Assumes 64-bit lanes carrying IEEE-754 binary64 inputs.
package pvec_cvt_pkg;

    localparam int ELEM_W = 64;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_DOWN      = 2'b01,
        RM_UP        = 2'b10,
        RM_ZERO      = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic invalid;
        logic inexact;
    } cvt_flags_t;

    localparam logic [3:0]        RESV_OK = 4'b1111;
    localparam logic [ELEM_W-1:0] INDEF   = 64'h8000_0000_0000_0000;

endpackage

// File: rtl/pvec_f64_to_s64.sv
// Combinational binary64 to signed 64-bit integer converter for one lane.
// Honours four rounding modes. Returns INDEF with the invalid flag on NaN,
// infinity or out-of-range input, and raises inexact on any lost fraction.
// Assumes the caller registers the result.
module pvec_f64_to_s64
    import pvec_cvt_pkg::*;
(
    input  logic [ELEM_W-1:0] fp_in,
    input  rnd_mode_e         rmode,
    output logic [ELEM_W-1:0] int_out,
    output logic              inv,
    output logic              inex
);

    localparam int SIG_W  = 53;
    localparam int GRS_W  = 55;
    localparam int EXT_W  = SIG_W + GRS_W;

    logic               sgn;
    logic [10:0]        bexp;
    logic [51:0]        frac;
    logic [SIG_W-1:0]   sig;
    logic signed [12:0] uexp;
    logic signed [12:0] rdist;
    logic [6:0]         rsh;
    logic [5:0]         lsh;
    logic [EXT_W-1:0]   shd;
    logic [ELEM_W-1:0]  mag;
    logic [ELEM_W-1:0]  magr;
    logic               g_bit;
    logic               s_bit;
    logic               inc;
    logic               special;
    logic               neg_min;
    logic               too_big;
    logic               range_bad;

    // Unpack fields and compute the unbiased exponent
    always_comb begin
        sgn   = fp_in[63];
        bexp  = fp_in[62:52];
        frac  = fp_in[51:0];
        sig   = {(bexp != 11'd0), frac};
        uexp  = (bexp == 11'd0) ? -13'sd1022 : ($signed({2'b00, bexp}) - 13'sd1023);
        rdist = 13'sd52 - uexp;
        rsh   = (rdist > 13'sd55) ? 7'd55 : rdist[6:0];
        lsh   = bexp[5:0] - 6'd51;
    end

    // Align the significand into integer, guard and sticky parts
    always_comb begin
        shd   = {sig, {GRS_W{1'b0}}} >> rsh;
        if (uexp >= 13'sd52) begin
            mag   = {11'd0, sig} << lsh;
            g_bit = 1'b0;
            s_bit = 1'b0;
        end else begin
            mag   = {11'd0, shd[EXT_W-1:GRS_W]};
            g_bit = shd[GRS_W-1];
            s_bit = |shd[GRS_W-2:0];
        end
    end

    // Decide the rounding increment for the selected mode
    always_comb begin
        unique case (rmode)
            RM_NEAR_EVEN: inc = g_bit & (s_bit | mag[0]);
            RM_DOWN:      inc = sgn & (g_bit | s_bit);
            RM_UP:        inc = ~sgn & (g_bit | s_bit);
            default:      inc = 1'b0;
        endcase
        magr = mag + {63'd0, inc};
    end

    // Classify special and out-of-range inputs and form the result
    always_comb begin
        special   = (bexp == 11'h7FF);
        neg_min   = sgn && (uexp == 13'sd63) && (frac == 52'd0);
        too_big   = (uexp >= 13'sd63);
        range_bad = sgn ? (magr > INDEF) : magr[63];
        if (special || (too_big && !neg_min) || (!too_big && range_bad)) begin
            int_out = INDEF;
            inv     = 1'b1;
            inex    = 1'b0;
        end else if (neg_min) begin
            int_out = INDEF;
            inv     = 1'b0;
            inex    = 1'b0;
        end else begin
            int_out = sgn ? (~magr + 64'd1) : magr;
            inv     = 1'b0;
            inex    = g_bit | s_bit;
        end
    end

endmodule

// File: rtl/pvec_lane_ctrl.sv
// Decodes the per-operation controls into per-lane enables, the rounding
// mode, the broadcast select and the reserved-field fault.
// Assumes LANES is 8, so that 2'b10 and 2'b11 both select every lane.
module pvec_lane_ctrl
    import pvec_cvt_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [1:0]       vl_sel,
    input  logic [LANES-1:0] wmask,
    input  logic             mask_en,
    input  logic             mem_src,
    input  logic             bcst_rnd,
    input  logic [1:0]       emb_rc,
    input  logic [1:0]       glob_rc,
    input  logic [3:0]       resv_spec,
    output logic [LANES-1:0] act_lanes,
    output logic [LANES-1:0] cvt_lanes,
    output rnd_mode_e        rmode,
    output logic             bcast,
    output logic             fault
);

    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] act_cnt;

    // Map the vector-length code to an active lane count
    always_comb begin
        unique case (vl_sel)
            2'b00:   act_cnt = CNT_W'(2);
            2'b01:   act_cnt = CNT_W'(4);
            default: act_cnt = CNT_W'(LANES);
        endcase
    end

    // Build the active and converted lane vectors
    for (genvar j = 0; j < LANES; j++) begin : g_lane_en
        assign act_lanes[j] = (CNT_W'(j) < act_cnt);
        assign cvt_lanes[j] = act_lanes[j] & (wmask[j] | ~mask_en);
    end

    // Split the dual-use bit between rounding override and broadcast
    always_comb begin
        bcast = mem_src & bcst_rnd;
        rmode = (!mem_src && bcst_rnd && vl_sel[1]) ? rnd_mode_e'(emb_rc)
                                                    : rnd_mode_e'(glob_rc);
        fault = (resv_spec != RESV_OK);
    end

endmodule

// File: rtl/pvec_cvt_ctrl.sv
// Top level: routes source elements to one converter per lane, applies
// merge or zero masking, clears lanes beyond the vector length, ORs the
// flags of converted lanes and registers everything for a one-cycle
// valid-in/valid-out handshake. On a reserved-field fault the prior
// destination is passed through and no flags are reported.
module pvec_cvt_ctrl
    import pvec_cvt_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_in,
    input  logic [LANES*ELEM_W-1:0] src_vec,
    input  logic [LANES*ELEM_W-1:0] prior_vec,
    input  logic [LANES-1:0]        wmask,
    input  logic [1:0]              vl_sel,
    input  logic                    zero_masking,
    input  logic                    mask_en,
    input  logic                    mem_src,
    input  logic                    bcst_rnd,
    input  logic [1:0]              emb_rc,
    input  logic [1:0]              glob_rc,
    input  logic [3:0]              resv_spec,
    output logic                    valid_out,
    output logic [LANES*ELEM_W-1:0] dest_vec,
    output logic [1:0]              exc_flags,
    output logic                    ud_fault
);

    localparam int VEC_W = LANES * ELEM_W;

    logic [LANES-1:0] act_lanes;
    logic [LANES-1:0] cvt_lanes;
    rnd_mode_e        rmode;
    logic             bcast;
    logic             fault;
    logic [LANES-1:0] lane_inv;
    logic [LANES-1:0] lane_inex;
    logic [VEC_W-1:0] lane_res;
    cvt_flags_t       flags_d;
    logic [VEC_W-1:0] dest_d;

    pvec_lane_ctrl #(.LANES(LANES)) u_ctrl (
        .vl_sel    (vl_sel),
        .wmask     (wmask),
        .mask_en   (mask_en),
        .mem_src   (mem_src),
        .bcst_rnd  (bcst_rnd),
        .emb_rc    (emb_rc),
        .glob_rc   (glob_rc),
        .resv_spec (resv_spec),
        .act_lanes (act_lanes),
        .cvt_lanes (cvt_lanes),
        .rmode     (rmode),
        .bcast     (bcast),
        .fault     (fault)
    );

    // One converter and one masking mux per lane
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [ELEM_W-1:0] op;
        logic [ELEM_W-1:0] cvt;

        assign op = bcast ? src_vec[ELEM_W-1:0] : src_vec[j*ELEM_W +: ELEM_W];

        pvec_f64_to_s64 u_cvt (
            .fp_in   (op),
            .rmode   (rmode),
            .int_out (cvt),
            .inv     (lane_inv[j]),
            .inex    (lane_inex[j])
        );

        // Select converted, merged, zeroed or cleared lane content
        always_comb begin
            if (!act_lanes[j]) begin
                lane_res[j*ELEM_W +: ELEM_W] = '0;
            end else if (cvt_lanes[j]) begin
                lane_res[j*ELEM_W +: ELEM_W] = cvt;
            end else if (zero_masking) begin
                lane_res[j*ELEM_W +: ELEM_W] = '0;
            end else begin
                lane_res[j*ELEM_W +: ELEM_W] = prior_vec[j*ELEM_W +: ELEM_W];
            end
        end
    end

    // Combine flags of converted lanes and apply the fault override
    always_comb begin
        if (fault) begin
            dest_d  = prior_vec;
            flags_d = '0;
        end else begin
            dest_d          = lane_res;
            flags_d.invalid = |(lane_inv & cvt_lanes);
            flags_d.inexact = |(lane_inex & cvt_lanes);
        end
    end

    // Output register stage matching the single-cycle handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            dest_vec  <= '0;
            exc_flags <= '0;
            ud_fault  <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                dest_vec  <= dest_d;
                exc_flags <= flags_d;
                ud_fault  <= fault;
            end
        end
    end

endmodule

// File: rtl/pvec_cvt_ctrl_chk.sv
// Property checker for pvec_cvt_ctrl, attached to the top by bind.
// Assumes LANES is 8 and a single register stage between issue and result.
module pvec_cvt_ctrl_chk #(
    parameter int LANES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 valid_in,
    input logic [1:0]           vl_sel,
    input logic                 zero_masking,
    input logic                 mask_en,
    input logic [LANES-1:0]     wmask,
    input logic [3:0]           resv_spec,
    input logic [LANES*64-1:0]  prior_vec,
    input logic                 valid_out,
    input logic [LANES*64-1:0]  dest_vec,
    input logic [1:0]           exc_flags,
    input logic                 ud_fault
);

    // R12: result strobe follows the issue strobe by one cycle
    a_r12_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out == $past(valid_in));

    // R2: two-lane operation leaves the upper bits cleared
    a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && vl_sel == 2'b00 && resv_spec == 4'b1111)
        |=> (dest_vec[LANES*64-1:128] == '0));

    // R11: bad reserved field faults and passes prior data through
    a_r11_fault_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && resv_spec != 4'b1111)
        |=> (ud_fault && exc_flags == 2'b00 && dest_vec == $past(prior_vec)));

    // R4: masked-off lane 0 merges the prior value
    a_r4_merge_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && resv_spec == 4'b1111 && mask_en && !wmask[0] && !zero_masking)
        |=> (dest_vec[63:0] == $past(prior_vec[63:0])));

    // R5: masked-off lane 0 is zeroed
    a_r5_zero_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && resv_spec == 4'b1111 && mask_en && !wmask[0] && zero_masking)
        |=> (dest_vec[63:0] == 64'd0));

    // R10: no converted lane means no flags
    a_r10_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mask_en && wmask == '0)
        |=> (exc_flags == 2'b00));

endmodule

bind pvec_cvt_ctrl pvec_cvt_ctrl_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_pvec_cvt_ctrl.sv
`timescale 1ns/1ps
module tb_pvec_cvt_ctrl;

    localparam logic [63:0] NAN_D = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D2P5  = 64'h4004_0000_0000_0000;
    localparam logic [63:0] INDF  = 64'h8000_0000_0000_0000;
    localparam int NT = 18;
    // {double, rounding code, expected integer, expected {invalid, inexact}}
    localparam logic [131:0] TBL [NT] = '{
        {64'h3FF0_0000_0000_0000, 2'b00, 64'h0000_0000_0000_0001, 2'b00},
        {64'hBFF0_0000_0000_0000, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00},
        {64'h4004_0000_0000_0000, 2'b00, 64'h0000_0000_0000_0002, 2'b01},
        {64'h4004_0000_0000_0000, 2'b10, 64'h0000_0000_0000_0003, 2'b01},
        {64'hC004_0000_0000_0000, 2'b01, 64'hFFFF_FFFF_FFFF_FFFD, 2'b01},
        {64'hC004_0000_0000_0000, 2'b11, 64'hFFFF_FFFF_FFFF_FFFE, 2'b01},
        {64'h400C_0000_0000_0000, 2'b00, 64'h0000_0000_0000_0004, 2'b01},
        {64'h3FE0_0000_0000_0000, 2'b00, 64'h0000_0000_0000_0000, 2'b01},
        {64'h3FE8_0000_0000_0000, 2'b00, 64'h0000_0000_0000_0001, 2'b01},
        {64'h43E0_0000_0000_0000, 2'b00, 64'h8000_0000_0000_0000, 2'b10},
        {64'hC3E0_0000_0000_0000, 2'b00, 64'h8000_0000_0000_0000, 2'b00},
        {64'h7FF8_0000_0000_0000, 2'b00, 64'h8000_0000_0000_0000, 2'b10},
        {64'hFFF0_0000_0000_0000, 2'b11, 64'h8000_0000_0000_0000, 2'b10},
        {64'h0000_0000_0000_0000, 2'b00, 64'h0000_0000_0000_0000, 2'b00},
        {64'h0000_0000_0000_0001, 2'b10, 64'h0000_0000_0000_0001, 2'b01},
        {64'h4330_0000_0000_0001, 2'b00, 64'h0010_0000_0000_0001, 2'b00},
        {64'hBFE0_0000_0000_0000, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01},
        {64'h43D0_0000_0000_0000, 2'b00, 64'h4000_0000_0000_0000, 2'b00}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [511:0] src_vec = '0;
    logic [511:0] prior_vec = '0;
    logic [7:0]   wmask = '0;
    logic [1:0]   vl_sel = '0;
    logic         zero_masking = 1'b0;
    logic         mask_en = 1'b0;
    logic         mem_src = 1'b0;
    logic         bcst_rnd = 1'b0;
    logic [1:0]   emb_rc = '0;
    logic [1:0]   glob_rc = '0;
    logic [3:0]   resv_spec = 4'hF;
    logic         valid_out;
    logic [511:0] dest_vec;
    logic [1:0]   exc_flags;
    logic         ud_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    pvec_cvt_ctrl dut (.*);

    // Small positive integer to binary64
    function automatic logic [63:0] dbl_of(input int unsigned n);
        int e = 0;
        logic [63:0] m;
        for (int b = 0; b < 32; b++) if (n[b]) e = b;
        m = 64'(n) << (52 - e);
        return {1'b0, 11'(1023 + e), m[51:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one operation and wait until its result is visible
    task automatic fire();
        @(negedge clk);
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic set_ramp();
        for (int j = 0; j < 8; j++) begin
            src_vec[j*64 +: 64]   = dbl_of(j + 1);
            prior_vec[j*64 +: 64] = 64'hDEAD_0000_0000_0000 | 64'(j);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [511:0] exp;
        logic [63:0]  v;
        logic [63:0]  ev;
        logic [1:0]   ef;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12", "reset valid", 512'(valid_out), 512'd0);
        check("R12", "reset dest", dest_vec, 512'd0);
        check("R12", "reset flags/fault", 512'({exc_flags, ud_fault}), 512'd0);

        // R9/R2/R10: conversion table, two-lane, no masking
        for (int i = 0; i < NT; i++) begin
            v = TBL[i][131:68]; glob_rc = TBL[i][67:66];
            ev = TBL[i][65:2];  ef = TBL[i][1:0];
            for (int j = 0; j < 8; j++) src_vec[j*64 +: 64] = v;
            prior_vec = {8{64'h5555_5555_5555_5555}};
            vl_sel = 2'b00; mask_en = 1'b0;
            fire();
            check("R12", "valid", 512'(valid_out), 512'd1);
            check("R9", "lane0", 512'(dest_vec[63:0]), 512'(ev));
            check("R9", "lane1", 512'(dest_vec[127:64]), 512'(ev));
            check("R2", "upper", 512'(dest_vec[511:128]), 512'd0);
            check("R10", "flags", 512'(exc_flags), 512'(ef));
        end
        glob_rc = 2'b00;

        // R12: results hold, strobe drops
        @(negedge clk);
        check("R12", "valid low", 512'(valid_out), 512'd0);
        check("R12", "hold", 512'(dest_vec[63:0]), 512'(ev));

        // R4/R3: merging, mask A5, 8 lanes
        set_ramp(); vl_sel = 2'b10; mask_en = 1'b1; wmask = 8'hA5; zero_masking = 1'b0;
        fire();
        for (int j = 0; j < 8; j++)
            exp[j*64 +: 64] = wmask[j] ? 64'(j + 1) : prior_vec[j*64 +: 64];
        check("R4", "merge", dest_vec, exp);

        // R5: zeroing
        zero_masking = 1'b1;
        fire();
        for (int j = 0; j < 8; j++) exp[j*64 +: 64] = wmask[j] ? 64'(j + 1) : 64'd0;
        check("R5", "zeroing", dest_vec, exp);

        // R2/R6: four lanes with all mask bits set
        vl_sel = 2'b01; wmask = 8'hFF; zero_masking = 1'b0;
        fire();
        for (int j = 0; j < 8; j++) exp[j*64 +: 64] = (j < 4) ? 64'(j + 1) : 64'd0;
        check("R2", "vl256 clear", dest_vec, exp);

        // R1: code 11 selects eight lanes
        vl_sel = 2'b11; mask_en = 1'b0;
        fire();
        for (int j = 0; j < 8; j++) exp[j*64 +: 64] = 64'(j + 1);
        check("R1", "vl code 11", dest_vec, exp);

        // R6/R10: NaN in inactive and masked-off lanes raise no flags
        vl_sel = 2'b00; mask_en = 1'b1; wmask = 8'b1111_1101;
        src_vec[63:0] = dbl_of(1);
        for (int j = 1; j < 8; j++) src_vec[j*64 +: 64] = NAN_D;
        fire();
        check("R10", "masked flags", 512'(exc_flags), 512'd0);
        check("R4", "lane1 merged", 512'(dest_vec[127:64]), 512'(prior_vec[127:64]));
        check("R6", "upper ignored", 512'(dest_vec[511:128]), 512'd0);

        // R3: masking disabled converts lane 1 and flags it
        mask_en = 1'b0;
        fire();
        check("R3", "unmasked lane1", 512'(dest_vec[127:64]), 512'(INDF));
        check("R10", "unmasked flags", 512'(exc_flags), 512'b10);

        // R8: broadcast from memory
        set_ramp(); src_vec[63:0] = dbl_of(5);
        vl_sel = 2'b10; mem_src = 1'b1; bcst_rnd = 1'b1;
        fire();
        check("R8", "broadcast", dest_vec, {8{64'd5}});

        // R7: memory form ignores embedded rounding
        src_vec[63:0] = D2P5; emb_rc = 2'b10; glob_rc = 2'b00;
        fire();
        check("R7", "mem global rc", dest_vec, {8{64'd2}});

        // R8: memory without broadcast uses own elements
        set_ramp(); bcst_rnd = 1'b0;
        fire();
        for (int j = 0; j < 8; j++) exp[j*64 +: 64] = 64'(j + 1);
        check("R8", "mem no bcst", dest_vec, exp);

        // R7: register source embedded rounding only at full length
        mem_src = 1'b0; bcst_rnd = 1'b1;
        for (int j = 0; j < 8; j++) src_vec[j*64 +: 64] = D2P5;
        fire();
        check("R7", "emb rc 512", 512'(dest_vec[63:0]), 512'd3);
        vl_sel = 2'b01;
        fire();
        check("R7", "emb rc 256 ignored", 512'(dest_vec[63:0]), 512'd2);
        vl_sel = 2'b10; bcst_rnd = 1'b0;
        fire();
        check("R7", "b=0 global", 512'(dest_vec[63:0]), 512'd2);

        // R11: reserved field fault
        set_ramp(); resv_spec = 4'hE;
        fire();
        check("R11", "fault flag", 512'(ud_fault), 512'd1);
        check("R11", "dest passthru", dest_vec, prior_vec);
        check("R11", "no flags", 512'(exc_flags), 512'd0);
        resv_spec = 4'hF;
        fire();
        check("R11", "fault clear", 512'(ud_fault), 512'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule